// File: doc/BRIEF.md
# Parity-Checked Byte Memory

This block is a small synchronous byte memory that keeps one check bit beside every stored byte. A write stores the byte and an even-parity bit generated from it. A read returns the byte and a parity bit one clock later. In the checked storage mode, the stored bit is compared against parity recomputed from the byte. A disagreement sets a sticky error flag, records the failing address and raises a halt output. While halt is high, read results are withheld, so that a consumer never takes in data after a fault.

Two configuration inputs shape the behaviour. The first, `chk_en`, arms or disarms error reporting. The second, `emul_mode`, selects an emulated mode in which the delivered parity bit is generated from the byte being read instead of being taken from storage. In that mode a fault can never be reported. For test purposes, `wr_flip_par` corrupts the stored check bit of the byte being written. A synchronous `err_clr` input returns the error state to idle.

Top module: `parity_byte_mem`

## Requirements
- R1: A read strobe with address A produces, one clock later, the byte last written to A on `rd_data`, together with a one-cycle `rd_valid` pulse.
- R2: In checked mode (`emul_mode`=0), `rd_par` carries the stored check bit. A clean write stores the XOR of the 8 data bits, which is even parity.
- R3: In checked mode with `chk_en`=1, a read whose stored bit differs from the XOR of its byte sets `err_flag` and `halt`. Both rise in the same cycle as that read's `rd_valid`.
- R4: `err_addr` takes the address of the first failing read. Later failures leave it unchanged until the error state is cleared.
- R5: `halt` stays high until cleared. While it is high, reads produce no `rd_valid` pulse.
- R6: In emulated mode (`emul_mode`=1), `rd_par` equals the XOR of the delivered byte, and no read can set `err_flag` or `halt`.
- R7: With `chk_en`=0, mismatching reads leave `err_flag` and `halt` low. `rd_par` still carries the stored bit.
- R8: `err_clr` drives `err_flag` and `halt` to 0 and `err_addr` to 0 on the next edge. If a failing read arrives in the same cycle, `err_clr` takes priority.
- R9: After reset, `err_flag`, `halt` and `rd_valid` are 0 and `err_addr` is 0.
- R10: When a read and a write target the same address in the same cycle, the read returns the contents held before that write.
- R11: A write with `wr_flip_par`=1 stores the inverse of the even-parity bit of its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write byte |
| wr_flip_par | input | 1 | Test only: invert the stored check bit of this write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read byte, one cycle after the strobe |
| rd_par | output | 1 | Parity bit delivered with the read byte |
| rd_valid | output | 1 | Read result valid pulse |
| chk_en | input | 1 | Enables error reporting |
| emul_mode | input | 1 | 1 selects emulated parity, 0 selects stored parity |
| err_clr | input | 1 | Synchronous clear of the error state |
| err_flag | output | 1 | Sticky parity error flag |
| halt | output | 1 | Sticky stop request; suppresses read valid |
| err_addr | output | ADDR_W | Address of the first failing read |

## Verification
The bench goes after the following corner cases:

- **Second failure overwriting the address.** The bench triggers a second failure after the first. A design that overwrote `err_addr` would report the later address.
- **Clear racing a failing read.** The bench clears in the same cycle as a failing read. A design that let the error win would come out of the clear still halted.
- **Same-cycle read and write.** The bench reads and writes one address in the same cycle. A design that forwarded the new byte would return it instead of the old one.
- **Corrupted bit in the other modes.** The bench reads a corrupted location in emulated mode and with checking off. A design that got these wrong would either flag an error or deliver the wrong parity bit.
- **Reads while halted.** The bench reads while halt is high. A design that ignored halt would still pulse `rd_valid`.

// File: rtl/parity_byte_mem.sv
module parity_byte_mem #(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_flip_par,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_par,
  output logic              rd_valid,
  input  logic              chk_en,
  input  logic              emul_mode,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              halt,
  output logic [ADDR_W-1:0] err_addr
);

  logic [7:0]       mem_d [DEPTH];
  logic [DEPTH-1:0] mem_p;

  wire [7:0] rbyte    = mem_d[rd_addr];
  wire       rpar_gen = ^rbyte;
  wire       rpar_st  = mem_p[rd_addr];
  wire       mism     = rd_en & chk_en & ~emul_mode & (rpar_gen ^ rpar_st);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_d[wr_addr] <= wr_data;
      mem_p[wr_addr] <= (^wr_data) ^ wr_flip_par;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_par  <= 1'b0;
    end else if (rd_en) begin
      rd_data <= rbyte;
      rd_par  <= emul_mode ? rpar_gen : rpar_st;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      err_flag <= 1'b0;
      halt     <= 1'b0;
      err_addr <= '0;
    end else begin
      rd_valid <= rd_en & ~halt;
      if (err_clr) begin
        err_flag <= 1'b0;
        halt     <= 1'b0;
        err_addr <= '0;
      end else if (mism) begin
        err_flag <= 1'b1;
        halt     <= 1'b1;
        if (!err_flag) err_addr <= rd_addr;
      end
    end
  end

  a_r1_valid_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  a_r3_err_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(chk_en) && $past(rd_en));
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> $stable(err_addr));
  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !err_clr |=> halt);
  a_r5_no_valid_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !rd_valid);
  a_r6_emul_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag && emul_mode |=> !err_flag);
  a_r6_emul_par: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(emul_mode) |-> rd_par == ^rd_data);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_flag && !halt && err_addr == '0);

endmodule

// File: tb/parity_byte_mem_tb.sv
`timescale 1ns/1ps
module parity_byte_mem_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_flip_par = 0, rd_en = 0, chk_en = 1, emul_mode = 0, err_clr = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rd_par, rd_valid, err_flag, halt;
  logic [5:0] err_addr;

  always #2.5 clk = ~clk;

  parity_byte_mem #(.ADDR_W(6)) u_dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] md [64];
  bit mp [64];
  bit m_err = 0;
  logic [5:0] m_addr = 0;

  function automatic bit epar(logic [7:0] d);
    return ^d;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic op(bit we, logic [5:0] wa, logic [7:0] wd, bit fl, bit re,
                    logic [5:0] ra, bit clr, bit chk_i, bit emu, string req);
    logic [7:0] e_d = md[ra];
    bit e_p = emu ? epar(md[ra]) : mp[ra];
    bit e_v = re && !m_err;
    bit mism = re && chk_i && !emu && (mp[ra] != epar(md[ra]));
    wr_en = we; wr_addr = wa; wr_data = wd; wr_flip_par = fl;
    rd_en = re; rd_addr = ra; err_clr = clr; chk_en = chk_i; emul_mode = emu;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; err_clr = 0; wr_flip_par = 0;
    if (we) begin md[wa] = wd; mp[wa] = epar(wd) ^ fl; end
    if (clr) begin m_err = 0; m_addr = 0; end
    else if (mism) begin
      if (!m_err) m_addr = ra;
      m_err = 1;
    end
    if (re || clr) begin
      chk(rd_valid == e_v, req, "rd_valid", rd_valid, e_v);
      if (e_v) begin
        chk(rd_data == e_d, req, "rd_data", rd_data, e_d);
        chk(rd_par == e_p, req, "rd_par", rd_par, e_p);
      end
      chk(err_flag == m_err, req, "err_flag", err_flag, m_err);
      chk(halt == m_err, req, "halt", halt, m_err);
      chk(err_addr == m_addr, req, "err_addr", err_addr, m_addr);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    int unsigned seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(!err_flag && !halt && !rd_valid, "R9", "flags", {err_flag, halt, rd_valid}, 0);
    chk(err_addr == 0, "R9", "err_addr", err_addr, 0);

    for (int i = 0; i < 64; i++) op(1, 6'(i), 8'($urandom), 0, 0, 0, 0, 1, 0, "R1");

    op(1, 5, 8'hA5, 0, 0, 0, 0, 1, 0, "R1");
    op(0, 0, 0, 0, 1, 5, 0, 1, 0, "R1");
    op(1, 7, 8'h01, 0, 0, 0, 0, 1, 0, "R2");
    op(0, 0, 0, 0, 1, 7, 0, 1, 0, "R2");
    op(1, 9, 8'h3C, 0, 1, 9, 0, 1, 0, "R10");
    op(0, 0, 0, 0, 1, 9, 0, 1, 0, "R10");
    op(1, 12, 8'h6B, 1, 0, 0, 0, 1, 0, "R11");
    op(0, 0, 0, 0, 1, 12, 0, 1, 0, "R3");
    op(1, 20, 8'h80, 1, 0, 0, 0, 1, 0, "R11");
    op(0, 0, 0, 0, 1, 20, 0, 1, 0, "R5");
    op(0, 0, 0, 0, 1, 20, 0, 1, 0, "R4");
    op(0, 0, 0, 0, 1, 20, 1, 1, 0, "R8");
    op(0, 0, 0, 0, 1, 20, 1, 1, 0, "R8");
    op(0, 0, 0, 0, 1, 20, 0, 1, 0, "R4");
    op(0, 0, 0, 0, 0, 0, 1, 1, 0, "R8");
    op(0, 0, 0, 0, 1, 20, 0, 1, 1, "R6");
    op(0, 0, 0, 0, 1, 12, 0, 1, 1, "R6");
    op(0, 0, 0, 0, 1, 20, 0, 0, 0, "R7");
    op(0, 0, 0, 0, 1, 12, 0, 0, 0, "R7");

    for (int i = 0; i < 800; i++) begin
      op($urandom_range(0, 1), 6'($urandom), 8'($urandom), $urandom_range(0, 7) == 0,
         $urandom_range(0, 3) != 0, 6'($urandom), $urandom_range(0, 5) == 0,
         $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0, "RND");
    end
    if (seed == 0) $display("seed zero");
    finish_run();
  end
endmodule